// File: doc/BRIEF.md
# Word Cache with Run-Time Selectable Associativity

This block is a small data cache that always holds 64 single-word lines of 32 bits. A two-bit mode input arranges those lines as one direct-mapped bank of 64 sets, as two ways of 32 sets, or as four ways of 16 sets. The total capacity stays the same in every mode. The index shrinks as the number of ways grows, and the number of tag comparisons grows with it. This lets the same access trace be run against each organisation so that their hit and miss counts can be compared.

The block accepts one access at a time. Each access is a byte address, a read or write flag and write data. A lookup compares the request tag against every enabled way of the chosen set in the same cycle. A read hit returns the cached word. A read miss fetches the word from a backing memory that answers one cycle after it is asked, places the word in the set, and returns it. Writes always go through to memory. A write that hits also updates the cached copy, and a write that misses leaves the cache alone. Two counters record hits and misses, and a one-cycle pulse marks each finished access.

Top module: `word_cache`

## Requirements
- R1: After reset every line is invalid, both counters read zero and `done` is low. The first read of any address is therefore a miss.
- R2: Address bits [1:0] play no part in lookup. The word address is `addr[ADDR_W-1:2]`. The mode sets the index width and the number of ways: mode 00 uses a 6-bit index with 1 way, mode 01 a 5-bit index with 2 ways, and modes 10 and 11 a 4-bit index with 4 ways. The index is the low bits of the word address. The tag is the word-address bits above the index.
- R3: An access hits only when an enabled way of the selected set is valid and holds the request tag. At most one way matches. A read hit returns the cached word, and `done` rises with `hit`=1 two cycles after the cycle in which the request is presented.
- R4: A read miss issues one backing read (`mem_en`=1, `mem_we`=0) at the word's byte address with bits [1:0] zero. The returned word is written into the set and presented on `rdata`. `done` rises with `hit`=0 three cycles after the request is presented.
- R5: A fill goes into the lowest-numbered invalid way of the set, if one exists.
- R6: When every way of the set is valid, a fill replaces the least recently used way. Every hit and every fill makes the accessed way the most recent one in its set.
- R7: Every write issues a backing write carrying the request data and the word's byte address, in the cycle after the request is presented. A write hit updates the cached word. A write miss allocates no line, so a later read of that address misses. Writes complete in two cycles.
- R8: `done` is a one-cycle pulse for each finished access. Exactly one of `hit_count` and `miss_count` increments on that edge, chosen by `hit`.
- R9: Any change of `mode` invalidates every line, resets the replacement order and clears both counters. The change must be made while no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Associativity select: 00 one way, 01 two ways, 10/11 four ways |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Result of the completed access, valid with `done` |
| rdata | output | DATA_W | Read result, valid with `done` on reads |
| mem_en | output | 1 | Backing memory access strobe |
| mem_we | output | 1 | Backing memory write enable |
| mem_addr | output | ADDR_W | Backing memory byte address |
| mem_wdata | output | DATA_W | Backing memory write data |
| mem_rdata | input | DATA_W | Backing memory read data, one cycle after a read strobe |
| hit_count | output | CNT_W | Hits since reset or last mode change |
| miss_count | output | CNT_W | Misses since reset or last mode change |

## Verification
The bench builds the block with its defaults: 64 lines, a 16-bit address and 32-bit counters. It uses a backing memory of 1024 words covering the lowest 4 KiB. Byte strides of 256, 128 and 64 land on the same set in the three modes. With the defaults, the bench can therefore force a direct-mapped conflict, fill both ways of one set and then evict by recency, and fill all four ways of one set and then evict the way that least recent use selects. Each of these is followed by checks of the replacement choice through later hits and misses.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } wc_state_e;

  // log2 of the number of ways selected by a mode value
  function automatic int unsigned way_bits(input logic [1:0] m);
    case (m)
      2'b00:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int unsigned idx_bits(input logic [1:0] m, input int unsigned line_w);
    return line_w - way_bits(m);
  endfunction

  function automatic int unsigned set_of(input logic [1:0] m, input logic [31:0] waddr,
                                         input int unsigned line_w);
    return waddr & ((32'd1 << idx_bits(m, line_w)) - 32'd1);
  endfunction

  function automatic int unsigned tag_of(input logic [1:0] m, input logic [31:0] waddr,
                                         input int unsigned line_w);
    return waddr >> idx_bits(m, line_w);
  endfunction

  // physical line holding a given way of a given set
  function automatic int unsigned line_of(input logic [1:0] m, input int unsigned set,
                                          input int unsigned way, input int unsigned line_w);
    return (way << idx_bits(m, line_w)) | set;
  endfunction

endpackage

// File: rtl/wc_lookup.sv
module wc_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0]            way_en,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][AGE_W-1:0] way_age,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [AGE_W-1:0]           oldest,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit_any,
  output logic [AGE_W-1:0]           hit_way,
  output logic [AGE_W-1:0]           vict_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_en[w] && way_valid[w] && (way_tag[w] == req_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = AGE_W'(w);
  end

  // oldest valid way first, then let the lowest invalid way override it
  always_comb begin
    vict_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_en[w] && way_age[w] == oldest) vict_way = AGE_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (way_en[w] && !way_valid[w]) vict_way = AGE_W'(w);
  end

endmodule

// File: rtl/wc_counters.sv
module wc_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_hit,
  input  logic             inc_miss,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hits   <= '0;
      misses <= '0;
    end else begin
      if (inc_hit)  hits   <= hits + CNT_W'(1);
      if (inc_miss) misses <= misses + CNT_W'(1);
    end
  end

endmodule

// File: rtl/word_cache.sv
module word_cache
  import wc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              hit,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int LINE_W   = $clog2(LINES);
  localparam int MAX_WAYS = 4;
  localparam int AGE_W    = $clog2(MAX_WAYS);
  localparam int WADDR_W  = ADDR_W - 2;
  localparam int TAG_W    = WADDR_W - (LINE_W - AGE_W);

  wc_state_e           st;
  logic [1:0]          mode_q;
  logic                q_write;
  logic [WADDR_W-1:0]  q_waddr;
  logic [DATA_W-1:0]   q_wdata;

  logic                valid_r [LINES];
  logic [TAG_W-1:0]    tag_r   [LINES];
  logic [DATA_W-1:0]   data_r  [LINES];
  logic [AGE_W-1:0]    age_r   [LINES];

  // named internal events used by the checker
  logic                flush;
  logic                accept;
  logic                touch_en;
  logic                fill_en;
  logic                wr_upd_en;

  logic [LINE_W-1:0]   set_idx;
  logic [TAG_W-1:0]    req_tag;
  logic [AGE_W-1:0]    oldest;
  logic [LINE_W-1:0]   way_line [MAX_WAYS];
  logic [MAX_WAYS-1:0] way_en;
  logic [MAX_WAYS-1:0] way_valid;
  logic [MAX_WAYS-1:0][TAG_W-1:0] way_tag;
  logic [MAX_WAYS-1:0][AGE_W-1:0] way_age;

  logic [MAX_WAYS-1:0] lk_hit_vec;
  logic                lk_hit;
  logic [AGE_W-1:0]    lk_hit_way;
  logic [AGE_W-1:0]    lk_vict_way;
  logic [AGE_W-1:0]    touch_way;
  logic [AGE_W-1:0]    touch_rank;
  logic                inc_hit;
  logic                inc_miss;

  assign flush  = (mode != mode_q);
  assign accept = (st == ST_IDLE) && req_valid && !flush;

  assign set_idx = LINE_W'(set_of(mode_q, 32'(q_waddr), LINE_W));
  assign req_tag = TAG_W'(tag_of(mode_q, 32'(q_waddr), LINE_W));
  assign oldest  = AGE_W'((1 << way_bits(mode_q)) - 1);

  for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
    assign way_line[w]  = LINE_W'(line_of(mode_q, 32'(set_idx), w, LINE_W));
    assign way_en[w]    = (w < (1 << way_bits(mode_q)));
    assign way_valid[w] = valid_r[way_line[w]];
    assign way_tag[w]   = tag_r[way_line[w]];
    assign way_age[w]   = age_r[way_line[w]];
  end

  wc_lookup #(.WAYS(MAX_WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_lookup (
    .way_en   (way_en),
    .way_valid(way_valid),
    .way_tag  (way_tag),
    .way_age  (way_age),
    .req_tag  (req_tag),
    .oldest   (oldest),
    .hit_vec  (lk_hit_vec),
    .hit_any  (lk_hit),
    .hit_way  (lk_hit_way),
    .vict_way (lk_vict_way)
  );

  assign fill_en    = !flush && (st == ST_FILL);
  assign wr_upd_en  = !flush && (st == ST_LOOK) && q_write && lk_hit;
  assign touch_en   = (!flush && (st == ST_LOOK) && lk_hit) || fill_en;
  assign touch_way  = (st == ST_FILL) ? lk_vict_way : lk_hit_way;
  assign touch_rank = way_age[touch_way];

  assign inc_hit  = !flush && (st == ST_LOOK) && lk_hit;
  assign inc_miss = !flush && (((st == ST_LOOK) && q_write && !lk_hit) || (st == ST_FILL));

  assign mem_en    = (st == ST_LOOK) && (q_write || !lk_hit);
  assign mem_we    = q_write;
  assign mem_addr  = {q_waddr, 2'b00};
  assign mem_wdata = q_wdata;

  // control path
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mode_q  <= 2'b00;
      q_write <= 1'b0;
      q_waddr <= '0;
      q_wdata <= '0;
      done    <= 1'b0;
      hit     <= 1'b0;
      rdata   <= '0;
    end else if (flush) begin
      st     <= ST_IDLE;
      mode_q <= mode;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          q_write <= req_write;
          q_waddr <= req_addr[ADDR_W-1:2];
          q_wdata <= req_wdata;
          st      <= ST_LOOK;
        end
        ST_LOOK: begin
          if (q_write || lk_hit) begin
            done <= 1'b1;
            hit  <= lk_hit;
            if (!q_write) rdata <= data_r[way_line[lk_hit_way]];
            st <= ST_IDLE;
          end else begin
            st <= ST_FILL;
          end
        end
        ST_FILL: begin
          done  <= 1'b1;
          hit   <= 1'b0;
          rdata <= mem_rdata;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // line state: valid, tag and recency rank
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < LINES; i++) begin
        valid_r[i] <= 1'b0;
        tag_r[i]   <= '0;
        age_r[i]   <= AGE_W'(i >> idx_bits(rst ? 2'b00 : mode, LINE_W));
      end
    end else begin
      if (fill_en) begin
        valid_r[way_line[lk_vict_way]] <= 1'b1;
        tag_r[way_line[lk_vict_way]]   <= req_tag;
      end
      if (touch_en) begin
        for (int w = 0; w < MAX_WAYS; w++) begin
          if (way_en[w]) begin
            if (AGE_W'(w) == touch_way)
              age_r[way_line[w]] <= '0;
            else if (way_age[w] < touch_rank)
              age_r[way_line[w]] <= way_age[w] + AGE_W'(1);
          end
        end
      end
    end
  end

  // data words need no reset
  always_ff @(posedge clk) begin
    if (fill_en)   data_r[way_line[lk_vict_way]] <= mem_rdata;
    if (wr_upd_en) data_r[way_line[lk_hit_way]]  <= q_wdata;
  end

  wc_counters #(.CNT_W(CNT_W)) u_counters (
    .clk     (clk),
    .rst     (rst),
    .clr     (flush),
    .inc_hit (inc_hit),
    .inc_miss(inc_miss),
    .hits    (hit_count),
    .misses  (miss_count)
  );

endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             done,
  input logic             hit,
  input logic             mem_en,
  input logic             mem_we,
  input logic [3:0]       hit_vec,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);

  assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_read_fill_R4: assert property (@(posedge clk) disable iff (rst || flush)
    (mem_en && !mem_we) |-> ##2 (done && !hit));

  assert_write_through_R7: assert property (@(posedge clk) disable iff (rst || flush)
    (mem_en && mem_we) |=> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst || flush)
    done |-> (hit ? (hit_count == $past(hit_count) + CNT_W'(1) && miss_count == $past(miss_count))
                  : (miss_count == $past(miss_count) + CNT_W'(1) && hit_count == $past(hit_count))));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (hit_count == '0 && miss_count == '0));

endmodule

bind word_cache wc_checker #(.CNT_W(CNT_W)) u_wc_checker (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .done      (done),
  .hit       (hit),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .hit_vec   (lk_hit_vec),
  .hit_count (hit_count),
  .miss_count(miss_count)
);

// File: tb/word_cache_test.sv
module word_cache_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;
  localparam int MEM_WORDS = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode = 2'b00;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              done, hit;
  logic [DATA_W-1:0] rdata;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [CNT_W-1:0]  hit_count, miss_count;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [DATA_W-1:0] mem    [MEM_WORDS];
  logic [DATA_W-1:0] shadow [MEM_WORDS];
  logic [ADDR_W-1:0] wr_addr_seen;
  logic [DATA_W-1:0] wr_data_seen;
  int                wr_seen = 0;
  int                rd_seen = 0;

  // expected hit/miss totals since the last mode change
  int exp_hits = 0;
  int exp_miss = 0;

  always #5 clk = ~clk;

  word_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(64), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .mode(mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .hit(hit), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [DATA_W-1:0] seed_word(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i]    = seed_word(i);
      shadow[i] = seed_word(i);
    end
  end

  // single-cycle backing memory and port monitor
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_addr_seen <= mem_addr;
        wr_data_seen <= mem_wdata;
        wr_seen <= wr_seen + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rd_seen <= rd_seen + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one access, checked for hit, latency and read data
  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input bit exp_hit, input string req);
    int lat;
    int rd0;
    logic [DATA_W-1:0] exp_data;
    rd0 = rd_seen;
    exp_data = shadow[a[11:2]];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(hit == exp_hit, req, "hit flag", 32'(hit), 32'(exp_hit));
    if (wr) begin
      check(lat == 2, "R7", "write latency", 32'(lat), 32'd2);
      check(wr_addr_seen == {a[ADDR_W-1:2], 2'b00} && wr_data_seen == wd, "R7",
            "write-through data", wr_data_seen, wd);
      shadow[a[11:2]] = wd;
    end else begin
      check(lat == (exp_hit ? 2 : 3), exp_hit ? "R3" : "R4", "read latency",
            32'(lat), exp_hit ? 32'd2 : 32'd3);
      check(rdata == exp_data, req, "read data", rdata, exp_data);
      check(rd_seen - rd0 == (exp_hit ? 0 : 1), "R4", "backing reads",
            32'(rd_seen - rd0), exp_hit ? 32'd0 : 32'd1);
    end
    if (exp_hit) exp_hits++; else exp_miss++;
    @(negedge clk);
    check(!done, "R8", "done pulse width", 32'(done), 32'd0);
  endtask

  task automatic check_counts(input string tag);
    check(hit_count == CNT_W'(exp_hits), "R8", {tag, " hit_count"}, hit_count, 32'(exp_hits));
    check(miss_count == CNT_W'(exp_miss), "R8", {tag, " miss_count"}, miss_count, 32'(exp_miss));
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
    @(negedge clk);
    exp_hits = 0;
    exp_miss = 0;
    check(hit_count == '0 && miss_count == '0, "R9", "counters cleared on mode change",
          hit_count | miss_count, 32'd0);
  endtask

  task automatic t_reset;
    check(!done, "R1", "done after reset", 32'(done), 32'd0);
    check(hit_count == '0 && miss_count == '0, "R1", "counters after reset",
          hit_count | miss_count, 32'd0);
  endtask

  task automatic t_direct;
    access(1'b0, 16'h0000, '0, 1'b0, "R1");  // compulsory miss
    access(1'b0, 16'h0002, '0, 1'b1, "R2");  // byte offset ignored
    access(1'b0, 16'h0104, '0, 1'b0, "R4");  // line 1
    access(1'b0, 16'h0100, '0, 1'b0, "R2");  // line 0, new tag, evicts 0x000
    access(1'b0, 16'h0003, '0, 1'b0, "R2");  // 0x000 was replaced
    access(1'b0, 16'h0104, '0, 1'b1, "R3");
    check_counts("direct");
  endtask

  task automatic t_two_way;
    set_mode(2'b01);
    access(1'b0, 16'h0000, '0, 1'b0, "R9");  // lines were invalidated
    access(1'b0, 16'h0080, '0, 1'b0, "R5");  // same set, second way
    access(1'b0, 16'h0000, '0, 1'b1, "R2");
    access(1'b0, 16'h0080, '0, 1'b1, "R5");
    access(1'b0, 16'h0100, '0, 1'b0, "R6");  // evicts 0x000
    access(1'b0, 16'h0080, '0, 1'b1, "R6");
    access(1'b0, 16'h0000, '0, 1'b0, "R6");  // evicts 0x100
    access(1'b0, 16'h0080, '0, 1'b1, "R6");
    check_counts("two-way");
  endtask

  task automatic t_four_way;
    set_mode(2'b10);
    access(1'b0, 16'h0000, '0, 1'b0, "R5");
    access(1'b0, 16'h0040, '0, 1'b0, "R5");
    access(1'b0, 16'h0080, '0, 1'b0, "R5");
    access(1'b0, 16'h00C0, '0, 1'b0, "R5");
    access(1'b0, 16'h0000, '0, 1'b1, "R2");
    access(1'b0, 16'h0040, '0, 1'b1, "R3");
    access(1'b0, 16'h0080, '0, 1'b1, "R3");
    access(1'b0, 16'h00C0, '0, 1'b1, "R3");
    access(1'b0, 16'h0000, '0, 1'b1, "R6");  // 0x040 now oldest
    access(1'b0, 16'h0100, '0, 1'b0, "R6");  // evicts 0x040
    access(1'b0, 16'h0080, '0, 1'b1, "R6");
    access(1'b0, 16'h0000, '0, 1'b1, "R6");
    access(1'b0, 16'h0040, '0, 1'b0, "R6");  // evicts 0x0C0
    access(1'b0, 16'h0100, '0, 1'b1, "R6");
    access(1'b0, 16'h00C0, '0, 1'b0, "R6");
    check_counts("four-way");
  endtask

  task automatic t_writes;
    access(1'b1, 16'h0200, 32'hDEAD_0001, 1'b0, "R7");  // write miss
    access(1'b0, 16'h0200, '0, 1'b0, "R7");             // not allocated
    access(1'b1, 16'h0201, 32'hBEEF_0002, 1'b1, "R7");  // write hit
    access(1'b0, 16'h0200, '0, 1'b1, "R7");             // cached copy updated
    check(mem[10'h080] == 32'hBEEF_0002, "R7", "backing memory holds write",
          mem[10'h080], 32'hBEEF_0002);
    check_counts("writes");
  endtask

  task automatic t_mode_alias;
    set_mode(2'b11);
    access(1'b0, 16'h0000, '0, 1'b0, "R9");
    access(1'b0, 16'h0040, '0, 1'b0, "R2");
    access(1'b0, 16'h0080, '0, 1'b0, "R2");
    access(1'b0, 16'h00C0, '0, 1'b0, "R2");
    access(1'b0, 16'h0000, '0, 1'b1, "R2");  // four ways hold all of them
    check_counts("mode 11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_two_way();
    t_four_way();
    t_writes();
    t_mode_alias();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule